// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects a vector of level-sensitive interrupt sources and presents them to a processor on two separate request lines. One line is the normal-priority request and the other is the fast request. Each line has its own enable mask, and both masks act on the same raw vector. A bit can therefore be routed to either line, to both, or to neither. Source 0 also has a software latch, so firmware can raise and drop an interrupt by itself.

Software uses a word-addressed register port with a write strobe and a read path that is valid in the same cycle. Each mask has a set word and a clear word, so one field can change without a read-modify-write. Status words show the raw vector and the masked vector for each line. Both request outputs are plain levels formed directly from the state, so the output of one instance can drive a source input of another to build a cascade.

Top module: `dual_intc`

## Requirements
- R1: Raw bit n (n >= 1) equals source input n in the same cycle. Raw bit 0 is source input 0 ORed with the software latch. The raw vector reads back at word 1 and at word 9.
- R2: Word 0 reads raw AND normal-mask, and word 8 reads raw AND fast-mask.
- R3: A write to word 2 ORs the data into the normal mask. A write to word 3 clears each normal-mask bit that is 1 in the data. Word 2 reads the normal mask.
- R4: A write to word 10 ORs the data into the fast mask. A write to word 11 clears each fast-mask bit that is 1 in the data. Word 10 reads the fast mask.
- R5: A write to word 4 with data bit 0 = 1 sets the software latch, and a write to word 5 with data bit 0 = 1 clears it. Writes with data bit 0 = 0 leave it unchanged. Word 4 reads raw bit 0 in bit 0, with every other bit 0.
- R6: irq_out is 1 exactly when raw AND normal-mask is nonzero. It follows source inputs in the same cycle and follows register writes from the next cycle.
- R7: fiq_out is 1 exactly when raw AND fast-mask is nonzero, with the same timing as R6.
- R8: Reads of words 3, 5 and 11, and of any word other than 0, 1, 2, 4, 8, 9 and 10, return zero.
- R9: Writes to words 0, 1, 8 and 9, and to any undefined word, change no mask and no software latch.
- R10: After synchronous reset both masks and the software latch are zero, so irq_out and fiq_out are 0.
- R11: Writes to the normal-mask words leave the fast mask unchanged, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Level-sensitive interrupt sources |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | AW | Word address for reads and writes |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data for bus_addr, same cycle |
| irq_out | output | 1 | Normal interrupt request level |
| fiq_out | output | 1 | Fast interrupt request level |

## Verification
The bench builds the block with its defaults: 32 sources and a 6-bit word address. At these values every register bit lane has a source behind it, and the full 64-word address space can be swept. The sweep reaches every undefined word above the used range as well as the write-only holes between the defined words. The sources are driven with mixed bit patterns, so the bench can show that a set or clear touches only the bits given in the data. It also exercises the cases where source 0 is raised by the external pin and where it is raised by the software latch.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;

    localparam int unsigned DEF_NSRC = 32;
    localparam int unsigned DEF_AW   = 6;
    localparam int unsigned IDX_W    = 8;

    // Register word kinds; numeric word positions are fixed by decode_word.
    typedef enum logic [3:0] {
        WD_IRQ_PEND,
        WD_RAW_I,
        WD_IRQ_ENA,
        WD_IRQ_DIS,
        WD_SWI_SET,
        WD_SWI_CLR,
        WD_FIQ_PEND,
        WD_RAW_F,
        WD_FIQ_ENA,
        WD_FIQ_DIS,
        WD_NONE
    } word_e;

    typedef struct packed {
        logic irq_set;
        logic irq_clr;
        logic fiq_set;
        logic fiq_clr;
        logic swi_set;
        logic swi_clr;
    } wr_strobe_t;

    function automatic word_e decode_word(input logic [IDX_W-1:0] w);
        word_e k;
        case (w)
            8'd0:    k = WD_IRQ_PEND;
            8'd1:    k = WD_RAW_I;
            8'd2:    k = WD_IRQ_ENA;
            8'd3:    k = WD_IRQ_DIS;
            8'd4:    k = WD_SWI_SET;
            8'd5:    k = WD_SWI_CLR;
            8'd8:    k = WD_FIQ_PEND;
            8'd9:    k = WD_RAW_F;
            8'd10:   k = WD_FIQ_ENA;
            8'd11:   k = WD_FIQ_DIS;
            default: k = WD_NONE;
        endcase
        return k;
    endfunction

    function automatic wr_strobe_t make_strobes(input logic we, input word_e k,
                                                input logic bit0);
        wr_strobe_t s;
        s.irq_set = we && (k == WD_IRQ_ENA);
        s.irq_clr = we && (k == WD_IRQ_DIS);
        s.fiq_set = we && (k == WD_FIQ_ENA);
        s.fiq_clr = we && (k == WD_FIQ_DIS);
        s.swi_set = we && (k == WD_SWI_SET) && bit0;
        s.swi_clr = we && (k == WD_SWI_CLR) && bit0;
        return s;
    endfunction

    function automatic logic is_write_only(input word_e k);
        return (k == WD_IRQ_DIS) || (k == WD_SWI_CLR) ||
               (k == WD_FIQ_DIS) || (k == WD_NONE);
    endfunction

    function automatic logic is_status(input word_e k);
        return (k == WD_IRQ_PEND) || (k == WD_RAW_I) ||
               (k == WD_FIQ_PEND) || (k == WD_RAW_F);
    endfunction

endpackage

// File: rtl/intc_enable_reg.sv
module intc_enable_reg #(
    parameter int unsigned NSRC = dual_intc_pkg::DEF_NSRC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_stb,
    input  logic            clr_stb,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (set_stb) begin
            mask_q <= mask_q | wdata;
        end else if (clr_stb) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    // R3 / R4: set bits stick, other bits keep their value
    p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> (((mask_q & $past(wdata)) == $past(wdata)) &&
                     ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata)))));

    // R3 / R4: clear bits drop, other bits keep their value
    p_clr_bits_r4: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> (((mask_q & $past(wdata)) == '0) &&
                     ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata)))));

    // R9 / R11: no strobe, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(mask_q));

endmodule

// File: rtl/intc_swi_latch.sv
module intc_swi_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_stb,
    input  logic clr_stb,
    output logic swi_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            swi_q <= 1'b0;
        end else if (set_stb) begin
            swi_q <= 1'b1;
        end else if (clr_stb) begin
            swi_q <= 1'b0;
        end
    end

    p_swi_set_r5: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> swi_q);

    p_swi_clr_r5: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> !swi_q);

    p_swi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(swi_q));

endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux #(
    parameter int unsigned NSRC = dual_intc_pkg::DEF_NSRC
) (
    input  dual_intc_pkg::word_e sel,
    input  logic [NSRC-1:0]      raw,
    input  logic [NSRC-1:0]      irq_en,
    input  logic [NSRC-1:0]      fiq_en,
    output logic [NSRC-1:0]      rdata
);
    import dual_intc_pkg::*;

    always_comb begin
        rdata = '0;
        unique case (sel)
            WD_IRQ_PEND: rdata = raw & irq_en;
            WD_RAW_I,
            WD_RAW_F:    rdata = raw;
            WD_IRQ_ENA:  rdata = irq_en;
            WD_SWI_SET:  rdata[0] = raw[0];
            WD_FIQ_PEND: rdata = raw & fiq_en;
            WD_FIQ_ENA:  rdata = fiq_en;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/dual_intc.sv
module dual_intc #(
    parameter int unsigned NSRC = dual_intc_pkg::DEF_NSRC,
    parameter int unsigned AW   = dual_intc_pkg::DEF_AW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            irq_out,
    output logic            fiq_out
);
    import dual_intc_pkg::*;

    localparam int unsigned NBANK  = 2;
    localparam int unsigned B_IRQ  = 0;
    localparam int unsigned B_FIQ  = 1;

    logic [IDX_W-1:0] word_idx;
    word_e            wsel;
    wr_strobe_t       stb;
    logic [NBANK-1:0] set_v;
    logic [NBANK-1:0] clr_v;
    logic [NSRC-1:0]  en_q [NBANK];
    logic             swi_q;
    logic [NSRC-1:0]  raw;

    assign word_idx = IDX_W'(bus_addr);
    assign wsel     = decode_word(word_idx);
    assign stb      = make_strobes(bus_we, wsel, bus_wdata[0]);

    assign set_v[B_IRQ] = stb.irq_set;
    assign clr_v[B_IRQ] = stb.irq_clr;
    assign set_v[B_FIQ] = stb.fiq_set;
    assign clr_v[B_FIQ] = stb.fiq_clr;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        intc_enable_reg #(.NSRC(NSRC)) u_en (
            .clk     (clk),
            .rst     (rst),
            .set_stb (set_v[g]),
            .clr_stb (clr_v[g]),
            .wdata   (bus_wdata),
            .mask_q  (en_q[g])
        );
    end

    intc_swi_latch u_swi (
        .clk     (clk),
        .rst     (rst),
        .set_stb (stb.swi_set),
        .clr_stb (stb.swi_clr),
        .swi_q   (swi_q)
    );

    always_comb begin
        raw    = src_in;
        raw[0] = src_in[0] | swi_q;
    end

    assign irq_out = |(raw & en_q[B_IRQ]);
    assign fiq_out = |(raw & en_q[B_FIQ]);

    intc_read_mux #(.NSRC(NSRC)) u_rd (
        .sel    (wsel),
        .raw    (raw),
        .irq_en (en_q[B_IRQ]),
        .fiq_en (en_q[B_FIQ]),
        .rdata  (bus_rdata)
    );

    // R6: the normal line agrees with the masked status read port
    p_irq_matches_status_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(0)) |-> ((bus_rdata != '0) == irq_out));

    // R7: the fast line agrees with the masked status read port
    p_fiq_matches_status_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(8)) |-> ((bus_rdata != '0) == fiq_out));

    // R1: raw read port tracks the upper source inputs
    p_raw_tracks_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(1)) |-> (bus_rdata[NSRC-1:1] == src_in[NSRC-1:1]));

    // R8: write-only and undefined words read zero
    p_undef_zero_r8: assert property (@(posedge clk) disable iff (rst)
        is_write_only(wsel) |-> (bus_rdata == '0));

    // R9: status-word writes leave all state alone
    p_status_write_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_status(wsel)) |=>
            ($stable(en_q[B_IRQ]) && $stable(en_q[B_FIQ]) && $stable(swi_q)));

    // R11: a write to one bank's words leaves the other bank alone
    p_bank_isolation_r11: assert property (@(posedge clk) disable iff (rst)
        (stb.irq_set || stb.irq_clr) |=> $stable(en_q[B_FIQ]));

    // R10: after a reset edge both outputs are low
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!irq_out && !fiq_out));

endmodule

// File: tb/tb_dual_intc.sv
`timescale 1ns/1ps
module tb_dual_intc;

    localparam int unsigned NSRC = 32;
    localparam int unsigned AW   = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_in = '0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [NSRC-1:0] bus_wdata = '0;
    logic [NSRC-1:0] bus_rdata;
    logic            irq_out;
    logic            fiq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    dual_intc #(.NSRC(NSRC), .AW(AW)) dut (
        .clk, .rst, .src_in, .bus_we, .bus_addr, .bus_wdata,
        .bus_rdata, .irq_out, .fiq_out
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = AW'(w);
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_rd(input int w, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(w);
        #1;
        d = bus_rdata;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_in = v;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 irq_out after reset", 32'(irq_out), 0);
        check("R10 fiq_out after reset", 32'(fiq_out), 0);
        bus_rd(2, d);  check("R10 normal mask", d, 0);
        bus_rd(10, d); check("R10 fast mask", d, 0);
        bus_rd(4, d);  check("R10 soft latch", d, 0);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        set_src(32'hA5A5_0F0E);
        bus_rd(1, d); check("R1 raw at word 1", d, 32'hA5A5_0F0E);
        bus_rd(9, d); check("R1 raw at word 9", d, 32'hA5A5_0F0E);
        bus_rd(0, d); check("R2 masked normal with zero mask", d, 0);
        check("R6 irq low with zero mask", 32'(irq_out), 0);
    endtask

    task automatic t_irq_mask();
        logic [31:0] d;
        bus_wr(2, 32'hFF00_00F0);
        bus_wr(2, 32'h0000_0F01);
        bus_rd(2, d); check("R3 mask after two sets", d, 32'hFF00_0FF1);
        bus_wr(3, 32'hF000_0001);
        bus_rd(2, d); check("R3 mask after clear", d, 32'h0F00_0FF0);
        bus_rd(0, d); check("R2 masked normal status", d, 32'h0500_0F00);
        check("R6 irq high", 32'(irq_out), 1);
        bus_rd(10, d); check("R11 fast mask untouched", d, 0);
        check("R7 fiq low", 32'(fiq_out), 0);
        set_src(32'h0000_F00F);
        check("R6 irq follows input drop", 32'(irq_out), 0);
        set_src(32'h0000_0010);
        check("R6 irq follows input rise", 32'(irq_out), 1);
    endtask

    task automatic t_fiq_mask();
        logic [31:0] d;
        bus_wr(10, 32'h8000_0011);
        bus_rd(10, d); check("R4 fast mask set", d, 32'h8000_0011);
        check("R7 fiq high", 32'(fiq_out), 1);
        bus_rd(8, d); check("R2 masked fast status", d, 32'h0000_0010);
        bus_wr(11, 32'h0000_0010);
        bus_rd(10, d); check("R4 fast mask clear", d, 32'h8000_0001);
        check("R7 fiq low after clear", 32'(fiq_out), 0);
        bus_rd(2, d); check("R11 normal mask untouched", d, 32'h0F00_0FF0);
    endtask

    task automatic t_soft();
        logic [31:0] d;
        set_src(32'h0);
        bus_wr(4, 32'hFFFF_FFFE);
        bus_rd(4, d); check("R5 set with bit0 clear ignored", d, 0);
        bus_wr(4, 32'h0000_0001);
        bus_rd(4, d); check("R5 soft latch set", d, 1);
        bus_rd(1, d); check("R1 raw bit0 from soft latch", d, 1);
        check("R7 fiq from soft source", 32'(fiq_out), 1);
        check("R6 irq masked for source 0", 32'(irq_out), 0);
        set_src(32'hFFFF_FFFF);
        bus_rd(4, d); check("R5 word 4 shows bit0 only", d, 1);
        bus_wr(5, 32'hFFFF_FFFE);
        set_src(32'h0);
        bus_rd(4, d); check("R5 clear with bit0 clear ignored", d, 1);
        bus_wr(5, 32'h0000_0001);
        bus_rd(4, d); check("R5 soft latch cleared", d, 0);
        check("R7 fiq low after soft clear", 32'(fiq_out), 0);
        set_src(32'h0000_0001);
        bus_rd(4, d); check("R5 external source 0 on word 4", d, 1);
        set_src(32'h0);
    endtask

    task automatic t_undef_read();
        logic [31:0] d;
        int bad = 0;
        set_src(32'hFFFF_FFFF);
        for (int w = 0; w < (1 << AW); w++) begin
            if (w == 0 || w == 1 || w == 2 || w == 4 ||
                w == 8 || w == 9 || w == 10) continue;
            bus_rd(w, d);
            if (d !== 0) bad++;
            check($sformatf("R8 word %0d reads zero", w), d, 0);
        end
        set_src(32'h0);
    endtask

    task automatic t_ignored_write();
        logic [31:0] d;
        int ws [6] = '{0, 1, 8, 9, 6, 63};
        foreach (ws[i]) bus_wr(ws[i], 32'hFFFF_FFFF);
        bus_rd(2, d);  check("R9 normal mask unchanged", d, 32'h0F00_0FF0);
        bus_rd(10, d); check("R9 fast mask unchanged", d, 32'h8000_0001);
        bus_rd(4, d);  check("R9 soft latch unchanged", d, 0);
        check("R9 irq still low", 32'(irq_out), 0);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_raw();
        t_irq_mask();
        t_fiq_mask();
        t_soft();
        t_undef_read();
        t_ignored_write();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule